// File: doc/BRIEF.md
# DSI Video-Mode Packet Sequencer

This block walks one video frame line by line and produces the ordered list of packet headers a DSI host link sends for it. Each header is a data-ID byte and a 16-bit word count, offered to a downstream packet builder on a valid/ready handshake. The frame is split vertically into a sync region, a back porch, the active lines and a front porch. Each active line is split horizontally into sync, back porch, pixel and front porch slots. The sequencer moves no pixel payload and computes no ECC or checksum. It only decides which header comes next.

Configuration inputs set the length of each vertical region in lines and the byte length of each horizontal blanking region. Further inputs pick the pixel packet type, the virtual channel, burst or null-filled non-burst active periods, and whether the horizontal sync end marker is also sent on vertical blanking lines. Separate skip bits drop individual horizontal blanking regions. An automatic vertical mode drops the sync and back-porch lines. An enable appends an end-of-transmission marker to every line. The configuration must stay stable while a frame is in progress.

A one-cycle `frame_start` request while idle launches a frame. `frame_done` pulses once the last header of the last line has been accepted.

Top module: `dsi_vid_seq`

## Requirements
- R1: Every data-ID byte carries `vchan` in bits 7:6 and the 6-bit packet type in bits 5:0.
- R2: After reset `pkt_valid` and `frame_done` are low. `frame_start` launches a frame only while the sequencer is idle and is ignored while a frame runs.
- R3: The first line of a frame opens with type 0x01. The line right after the last vertical sync line (when that region is non-empty) opens with 0x11. Every other line opens with 0x21. Sync-type headers and the 0x08 marker carry word count 0.
- R4: A vertical blanking line (sync, back porch or front porch region) holds its opening header, then 0x31 only when `hse_en` is 1, then the end marker of R9.
- R5: An active line holds, in this order: opening header, blanking 0x19 with word count `hsa_wc`, 0x31, blanking 0x19 with `hbp_wc`, pixel packet, null fill, blanking 0x19 with `hfp_wc`, end marker.
- R6: `hsa_skip`, `hbp_skip` and `hfp_skip` each remove their own blanking header from active lines and leave the rest of the line unchanged.
- R7: With `burst_en` at 0 a null packet of type 0x09 and word count `null_wc` follows each pixel packet. With `burst_en` at 1 no null packet is sent.
- R8: The pixel packet type is `{pix_fmt, 4'hE}` (0 gives 0x0E, 1 gives 0x1E, 2 gives 0x2E, 3 gives 0x3E), and its word count is `hact_wc`.
- R9: When `eot_en` is 1 every line ends with type 0x08. When it is 0 no 0x08 header appears.
- R10: With `auto_vcnt` at 1 the sync and back-porch lines are not produced. The frame is `vact_lines` active lines followed by `vfp_lines` front-porch lines, and no 0x11 appears.
- R11: Vertical regions of zero lines are skipped without emitting anything. `vact_lines` must be at least 1.
- R12: While `pkt_valid` is high and `pkt_ready` is low, `pkt_di` and `pkt_wc` hold. The sequence advances only on an accepted header.
- R13: `frame_done` is high for exactly one cycle, the cycle after the last header of the frame is accepted, and `pkt_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Launch request for a frame |
| vsa_lines | input | LINE_W | Vertical sync region length in lines |
| vbp_lines | input | LINE_W | Vertical back porch length in lines |
| vact_lines | input | LINE_W | Active line count |
| vfp_lines | input | LINE_W | Vertical front porch length in lines |
| auto_vcnt | input | 1 | Drop the sync and back-porch lines |
| hsa_wc | input | WC_W | Horizontal sync blanking byte count |
| hbp_wc | input | WC_W | Horizontal back porch byte count |
| hact_wc | input | WC_W | Pixel packet byte count |
| null_wc | input | WC_W | Null fill byte count |
| hfp_wc | input | WC_W | Horizontal front porch byte count |
| hse_en | input | 1 | Also send 0x31 on vertical blanking lines |
| hsa_skip | input | 1 | Drop the horizontal sync blanking header |
| hbp_skip | input | 1 | Drop the horizontal back porch header |
| hfp_skip | input | 1 | Drop the horizontal front porch header |
| burst_en | input | 1 | Burst active period (no null fill) |
| eot_en | input | 1 | Append the end marker to every line |
| vchan | input | 2 | Virtual channel |
| pix_fmt | input | 2 | Pixel packet format code |
| pkt_valid | output | 1 | Header offered |
| pkt_ready | input | 1 | Downstream accepts the header |
| pkt_di | output | 8 | Data-ID byte |
| pkt_wc | output | WC_W | Word count |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
The bound checker checks these rules on every cycle: the header holds while it waits for acceptance, the channel field matches `vchan`, no null packet appears in burst mode, no end marker appears when it is disabled, a frame only begins after a start request, and the end pulse lasts one cycle, follows an accepted header and comes while the output is idle. The exact order of headers in a frame can only be shown by the bench's scenarios. Those scenarios cover the opening type of each line, the effect of `hse_en` on blanking lines, the skip bits, the auto vertical mode, zero-length regions and the word counts. A reference list of expected headers is built for each configuration and compared one by one against the accepted headers, with ready both held high and toggled irregularly.

// File: rtl/dsi_vseq_pkg.sv
package dsi_vseq_pkg;

   typedef enum logic [1:0] {
      RG_VSYNC  = 2'd0,
      RG_VBACK  = 2'd1,
      RG_VACT   = 2'd2,
      RG_VFRONT = 2'd3
   } vreg_e;

   // slot order inside a line is the emission order
   typedef enum logic [2:0] {
      SL_LSTART = 3'd0,
      SL_HSA    = 3'd1,
      SL_HSE    = 3'd2,
      SL_HBP    = 3'd3,
      SL_PIX    = 3'd4,
      SL_FILL   = 3'd5,
      SL_HFP    = 3'd6,
      SL_EOT    = 3'd7
   } slot_e;

   localparam int unsigned NUM_REGIONS = 4;
   localparam int unsigned NUM_SLOTS   = 8;

   localparam logic [5:0] DT_VSS   = 6'h01;
   localparam logic [5:0] DT_VSE   = 6'h11;
   localparam logic [5:0] DT_HSS   = 6'h21;
   localparam logic [5:0] DT_HSE   = 6'h31;
   localparam logic [5:0] DT_EOT   = 6'h08;
   localparam logic [5:0] DT_NULL  = 6'h09;
   localparam logic [5:0] DT_BLANK = 6'h19;
   localparam logic [3:0] DT_PIX_LO = 4'hE;

endpackage

// File: rtl/dsi_vseq_lines.sv
module dsi_vseq_lines
   import dsi_vseq_pkg::*;
#(
   parameter int unsigned LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_go,
   input  logic              line_adv,
   input  logic [LINE_W-1:0] len_vsa,
   input  logic [LINE_W-1:0] len_vbp,
   input  logic [LINE_W-1:0] len_vact,
   input  logic [LINE_W-1:0] len_vfp,
   input  logic              auto_vcnt,
   output logic              is_active,
   output logic              is_first,
   output logic              is_vse,
   output logic              is_last
);

   localparam int unsigned CW = LINE_W + 1;

   logic [NUM_REGIONS-1:0][LINE_W-1:0] eff_len;
   logic [NUM_REGIONS-1:0]             nz;
   vreg_e                              region_q, first_rg, nxt_rg;
   logic                               nxt_ok;
   logic [LINE_W-1:0]                  cnt_q;
   logic                               first_q, vse_q, cnt_wrap;

   assign eff_len[RG_VSYNC]  = auto_vcnt ? '0 : len_vsa;
   assign eff_len[RG_VBACK]  = auto_vcnt ? '0 : len_vbp;
   assign eff_len[RG_VACT]   = len_vact;
   assign eff_len[RG_VFRONT] = len_vfp;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_nz
      assign nz[g] = |eff_len[g];
   end

   // lowest non-empty region opens the frame; next non-empty one follows
   always_comb begin
      first_rg = RG_VACT;
      nxt_rg   = RG_VFRONT;
      nxt_ok   = 1'b0;
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
         if (nz[i]) first_rg = vreg_e'(2'(i));
         if (nz[i] && (i > int'(region_q))) begin
            nxt_rg = vreg_e'(2'(i));
            nxt_ok = 1'b1;
         end
      end
   end

   assign cnt_wrap = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, eff_len[region_q]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         region_q <= RG_VSYNC;
         cnt_q    <= '0;
         first_q  <= 1'b0;
         vse_q    <= 1'b0;
      end else if (frame_go) begin
         region_q <= first_rg;
         cnt_q    <= '0;
         first_q  <= 1'b1;
         vse_q    <= 1'b0;
      end else if (line_adv) begin
         first_q <= 1'b0;
         if (!cnt_wrap) begin
            cnt_q <= cnt_q + LINE_W'(1);
            vse_q <= 1'b0;
         end else begin
            cnt_q    <= '0;
            region_q <= nxt_rg;
            vse_q    <= (region_q == RG_VSYNC);
         end
      end
   end

   assign is_active = (region_q == RG_VACT);
   assign is_first  = first_q;
   assign is_vse    = vse_q;
   assign is_last   = cnt_wrap && !nxt_ok;

endmodule

// File: rtl/dsi_vseq_slots.sv
module dsi_vseq_slots
   import dsi_vseq_pkg::*;
#(
   parameter int unsigned WC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_go,
   input  logic            pkt_adv,
   input  logic            line_active,
   input  logic            first_line,
   input  logic            vse_line,
   input  logic            hse_en,
   input  logic            hsa_skip,
   input  logic            hbp_skip,
   input  logic            hfp_skip,
   input  logic            burst_en,
   input  logic            eot_en,
   input  logic [1:0]      pix_fmt,
   input  logic [WC_W-1:0] hsa_wc,
   input  logic [WC_W-1:0] hbp_wc,
   input  logic [WC_W-1:0] hact_wc,
   input  logic [WC_W-1:0] null_wc,
   input  logic [WC_W-1:0] hfp_wc,
   output logic [5:0]      slot_dt,
   output logic [WC_W-1:0] slot_wc,
   output logic            slot_last
);

   logic [NUM_SLOTS-1:0] en;
   slot_e                slot_q, nxt_slot;
   logic                 nxt_ok;

   // which slots this line carries
   always_comb begin
      en            = '0;
      en[SL_LSTART] = 1'b1;
      en[SL_HSA]    = line_active && !hsa_skip;
      en[SL_HSE]    = line_active || hse_en;
      en[SL_HBP]    = line_active && !hbp_skip;
      en[SL_PIX]    = line_active;
      en[SL_FILL]   = line_active && !burst_en;
      en[SL_HFP]    = line_active && !hfp_skip;
      en[SL_EOT]    = eot_en;
   end

   always_comb begin
      nxt_slot = SL_EOT;
      nxt_ok   = 1'b0;
      for (int i = NUM_SLOTS - 1; i > 0; i--) begin
         if (en[i] && (i > int'(slot_q))) begin
            nxt_slot = slot_e'(3'(i));
            nxt_ok   = 1'b1;
         end
      end
   end

   assign slot_last = !nxt_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)                slot_q <= SL_LSTART;
      else if (frame_go)         slot_q <= SL_LSTART;
      else if (pkt_adv)          slot_q <= nxt_ok ? nxt_slot : SL_LSTART;
   end

   always_comb begin
      slot_dt = DT_EOT;
      slot_wc = '0;
      case (slot_q)
         SL_LSTART: slot_dt = first_line ? DT_VSS : (vse_line ? DT_VSE : DT_HSS);
         SL_HSA:    begin slot_dt = DT_BLANK; slot_wc = hsa_wc; end
         SL_HSE:    slot_dt = DT_HSE;
         SL_HBP:    begin slot_dt = DT_BLANK; slot_wc = hbp_wc; end
         SL_PIX:    begin slot_dt = {pix_fmt, DT_PIX_LO}; slot_wc = hact_wc; end
         SL_FILL:   begin slot_dt = DT_NULL; slot_wc = null_wc; end
         SL_HFP:    begin slot_dt = DT_BLANK; slot_wc = hfp_wc; end
         default:   slot_dt = DT_EOT;
      endcase
   end

endmodule

// File: rtl/dsi_vid_seq.sv
module dsi_vid_seq
   import dsi_vseq_pkg::*;
#(
   parameter int unsigned LINE_W = 12,
   parameter int unsigned WC_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [LINE_W-1:0] vsa_lines,
   input  logic [LINE_W-1:0] vbp_lines,
   input  logic [LINE_W-1:0] vact_lines,
   input  logic [LINE_W-1:0] vfp_lines,
   input  logic              auto_vcnt,
   input  logic [WC_W-1:0]   hsa_wc,
   input  logic [WC_W-1:0]   hbp_wc,
   input  logic [WC_W-1:0]   hact_wc,
   input  logic [WC_W-1:0]   null_wc,
   input  logic [WC_W-1:0]   hfp_wc,
   input  logic              hse_en,
   input  logic              hsa_skip,
   input  logic              hbp_skip,
   input  logic              hfp_skip,
   input  logic              burst_en,
   input  logic              eot_en,
   input  logic [1:0]        vchan,
   input  logic [1:0]        pix_fmt,
   output logic              pkt_valid,
   input  logic              pkt_ready,
   output logic [7:0]        pkt_di,
   output logic [WC_W-1:0]   pkt_wc,
   output logic              frame_done
);

   if (LINE_W < 2 || LINE_W > 16) begin : g_bad_line_w
      $error("dsi_vid_seq: LINE_W must lie in 2..16");
   end
   if (WC_W < 8 || WC_W > 16) begin : g_bad_wc_w
      $error("dsi_vid_seq: WC_W must lie in 8..16");
   end

   logic       busy_q, done_q;
   logic       go, adv, line_end, frame_end;
   logic       ln_active, ln_first, ln_vse, ln_last, sl_last;
   logic [5:0] sl_dt;

   assign go        = frame_start && !busy_q;
   assign adv       = busy_q && pkt_ready;
   assign line_end  = adv && sl_last;
   assign frame_end = line_end && ln_last;

   dsi_vseq_lines #(.LINE_W(LINE_W)) u_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_go  (go),
      .line_adv  (line_end),
      .len_vsa   (vsa_lines),
      .len_vbp   (vbp_lines),
      .len_vact  (vact_lines),
      .len_vfp   (vfp_lines),
      .auto_vcnt (auto_vcnt),
      .is_active (ln_active),
      .is_first  (ln_first),
      .is_vse    (ln_vse),
      .is_last   (ln_last)
   );

   dsi_vseq_slots #(.WC_W(WC_W)) u_slots (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_go    (go),
      .pkt_adv     (adv),
      .line_active (ln_active),
      .first_line  (ln_first),
      .vse_line    (ln_vse),
      .hse_en      (hse_en),
      .hsa_skip    (hsa_skip),
      .hbp_skip    (hbp_skip),
      .hfp_skip    (hfp_skip),
      .burst_en    (burst_en),
      .eot_en      (eot_en),
      .pix_fmt     (pix_fmt),
      .hsa_wc      (hsa_wc),
      .hbp_wc      (hbp_wc),
      .hact_wc     (hact_wc),
      .null_wc     (null_wc),
      .hfp_wc      (hfp_wc),
      .slot_dt     (sl_dt),
      .slot_wc     (pkt_wc),
      .slot_last   (sl_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= frame_end;
         if (go)             busy_q <= 1'b1;
         else if (frame_end) busy_q <= 1'b0;
      end
   end

   assign pkt_valid  = busy_q;
   assign pkt_di     = {vchan, sl_dt};
   assign frame_done = done_q;

endmodule

// File: rtl/dsi_vid_seq_chk.sv
module dsi_vid_seq_chk #(
   parameter int unsigned WC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            frame_start,
   input logic            burst_en,
   input logic            eot_en,
   input logic [1:0]      vchan,
   input logic            pkt_valid,
   input logic            pkt_ready,
   input logic [7:0]      pkt_di,
   input logic [WC_W-1:0] pkt_wc,
   input logic            frame_done
);

   // R12
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_di) && $stable(pkt_wc));

   // R2
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_valid) |-> $past(frame_start));

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R13
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !pkt_valid && $past(pkt_valid && pkt_ready));

   // R1
   vc_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> pkt_di[7:6] == vchan);

   // R7
   no_fill_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && burst_en |-> pkt_di[5:0] != 6'h09);

   // R9
   no_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && !eot_en |-> pkt_di[5:0] != 6'h08);

endmodule

bind dsi_vid_seq dsi_vid_seq_chk #(.WC_W(WC_W)) u_chk (.*);

// File: tb/dsi_vid_seq_tb.sv
`timescale 1ns/1ps
module dsi_vid_seq_tb;
   localparam int LINE_W = 12;
   localparam int WC_W   = 16;

   logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
   logic [LINE_W-1:0] vsa_lines, vbp_lines, vact_lines, vfp_lines;
   logic auto_vcnt, hse_en, hsa_skip, hbp_skip, hfp_skip, burst_en, eot_en;
   logic [WC_W-1:0] hsa_wc, hbp_wc, hact_wc, null_wc, hfp_wc;
   logic [1:0] vchan, pix_fmt;
   logic pkt_valid, pkt_ready = 1'b1, frame_done;
   logic [7:0] pkt_di;
   logic [WC_W-1:0] pkt_wc;

   always #2 clk = ~clk;

   dsi_vid_seq #(.LINE_W(LINE_W), .WC_W(WC_W)) u_dut (.*);

   int checks = 0, errors = 0, rx_cnt = 0;
   bit rnd_ready = 0, finished = 0;
   logic [23:0] exp_q[$];
   string       tag_q[$];

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic push(logic [5:0] dt, logic [15:0] wc, string req);
      exp_q.push_back({vchan, dt, wc});
      tag_q.push_back(req);
   endtask

   // reference list of headers, derived from the requirements
   task automatic build_frame();
      int  lens[4];
      bit  first = 1, vse = 0;
      lens[0] = auto_vcnt ? 0 : int'(vsa_lines);
      lens[1] = auto_vcnt ? 0 : int'(vbp_lines);
      lens[2] = int'(vact_lines);
      lens[3] = int'(vfp_lines);
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < lens[r]; i++) begin
            push(first ? 6'h01 : (vse ? 6'h11 : 6'h21), 16'h0, "R3");
            first = 0;
            vse   = 0;
            if (r != 2) begin
               if (hse_en) push(6'h31, 16'h0, "R4");
            end else begin
               if (!hsa_skip) push(6'h19, hsa_wc, "R5");
               push(6'h31, 16'h0, "R5");
               if (!hbp_skip) push(6'h19, hbp_wc, "R5");
               push({pix_fmt, 4'hE}, hact_wc, "R8");
               if (!burst_en) push(6'h09, null_wc, "R7");
               if (!hfp_skip) push(6'h19, hfp_wc, "R5");
            end
            if (eot_en) push(6'h08, 16'h0, "R9");
         end
         if (r == 0 && lens[0] > 0) vse = 1;
      end
   endtask

   task automatic pulse_start();
      @(posedge clk); #1 frame_start = 1'b1;
      @(posedge clk); #1 frame_start = 1'b0;
   endtask

   task automatic run_frame(string cnt_req, bit poke_busy);
      int n_exp, n = 0;
      build_frame();
      n_exp  = exp_q.size();
      rx_cnt = 0;
      pulse_start();
      if (poke_busy) begin
         repeat (4) @(posedge clk);
         pulse_start();   // R2: frame running, request must be ignored
      end
      while (!frame_done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(frame_done == 1'b1, "R13 frame_done seen", 32'(frame_done), 32'h1);
      check(rx_cnt == n_exp, {cnt_req, " header count"}, rx_cnt, n_exp);
      repeat (3) @(negedge clk);
   endtask

   // ready driver, away from the sampling edge
   always @(posedge clk) begin
      #1 pkt_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
   end

   // monitor / scoreboard
   logic       pv_q = 0, pr_q = 0, hs_q = 0;
   logic [7:0] pdi_q;
   logic [15:0] pwc_q;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pv_q && !pr_q)
            check(pkt_valid && pkt_di == pdi_q && pkt_wc == pwc_q, "R12 hold",
                  {7'h0, pkt_valid, pkt_di, pkt_wc}, {8'h1, pdi_q, pwc_q});
         if (frame_done) begin
            check(hs_q && !pkt_valid, "R13 done timing", {hs_q, pkt_valid}, 2'b10);
            check(exp_q.size() == 0, "R13 queue drained", exp_q.size(), 0);
         end
         if (pkt_valid && pkt_ready) begin
            rx_cnt++;
            check(pkt_di[7:6] == vchan, "R1 channel field", pkt_di[7:6], vchan);
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected header", {pkt_di, pkt_wc}, 0);
            end else begin
               logic [23:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({pkt_di, pkt_wc} == e, t, {pkt_di, pkt_wc}, e);
            end
         end
         hs_q  <= pkt_valid && pkt_ready;
         pv_q  <= pkt_valid;
         pr_q  <= pkt_ready;
         pdi_q <= pkt_di;
         pwc_q <= pkt_wc;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      vsa_lines = 2; vbp_lines = 1; vact_lines = 3; vfp_lines = 2;
      auto_vcnt = 0; hse_en = 0; hsa_skip = 0; hbp_skip = 0; hfp_skip = 0;
      burst_en = 0; eot_en = 1; vchan = 2'd1; pix_fmt = 2'd3;
      hsa_wc = 16'h0010; hbp_wc = 16'h0024; hact_wc = 16'h0F00;
      null_wc = 16'h0042; hfp_wc = 16'h0018;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!pkt_valid && !frame_done, "R2 reset state", {pkt_valid, frame_done}, 0);

      // plain non-burst frame, ready always high
      run_frame("R5", 0);

      // sync-event marker on blanking lines, burst, HSA dropped, stalls
      hse_en = 1; burst_en = 1; hsa_skip = 1; vchan = 2'd2; pix_fmt = 2'd0;
      rnd_ready = 1;
      run_frame("R6", 0);

      // automatic vertical count, back and front porch dropped, no end marker
      hse_en = 0; burst_en = 0; hsa_skip = 0; hbp_skip = 1; hfp_skip = 1;
      auto_vcnt = 1; eot_en = 0; vchan = 2'd3; pix_fmt = 2'd1;
      run_frame("R10", 0);

      // empty sync and back porch regions, second start while busy
      auto_vcnt = 0; hbp_skip = 0; hfp_skip = 0; eot_en = 1;
      vsa_lines = 0; vbp_lines = 0; vact_lines = 4; vfp_lines = 1;
      vchan = 2'd0; pix_fmt = 2'd2;
      run_frame("R11", 1);
      repeat (8) @(negedge clk);
      check(!pkt_valid, "R2 ignored start stays idle", pkt_valid, 0);

      // one sync line then straight into active, no front porch
      vsa_lines = 1; vbp_lines = 0; vact_lines = 1; vfp_lines = 0;
      hse_en = 1; pix_fmt = 2'd3; vchan = 2'd1;
      run_frame("R3", 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule